// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Sequencer

This block sequences the row scan of a small multiplexed liquid-crystal panel with four common lines and forty segment lines. Each oscillator tick advances a frame position counter. From that position, the selected duty (one, two, three or four active rows) and the chosen bias (one third or one half), the block emits a three-bit level code for every common and every segment output. An analog stage outside the block turns each code into a voltage. Successive frames alternate polarity, so every pixel sees zero net DC.

The display contents arrive as four rows of forty bits. In the half and third duty modes, the unused common lines copy an active row, so a panel wired to any of the four lines still scans correctly. A master device emits a divided clock and a frame-start pulse for slave devices chained behind it. A slave takes its ticks from the master, restarts its frame on the master's pulse, and keeps its commons at ground. An optional blink gate, derived from the frame count, blanks the segments at a slow rate.

Top module: `lcd_mux_seq`

## Requirements
- R1: `duty_sel` picks the active rows: 2'b00 static (one row, all four commons on row 0), 2'b01 half (commons 0 and 2 on row 0, commons 1 and 3 on row 1), 2'b10 third (common k on row k, common 3 on row 1), 2'b11 quarter (common k on row k). Exactly one active row is selected at a time.
- R2: Level codes are 0 GND, 1 one third, 2 one half, 3 two thirds, 4 full rail. Let p be the frame polarity, 0 or 1.
  - A selected common drives 4 when p=0 and 0 when p=1.
  - An unselected common drives 1 and 3 on alternate frames with `half_bias`=0, and 2 with `half_bias`=1.
  - An on segment drives 0 when p=0 and 4 when p=1.
  - An off segment drives 3 when p=0 and 1 when p=1 with `half_bias`=0. With `half_bias`=1 it drives 4 when p=0 and 0 when p=1.
- R3: A frame lasts 24 ticks, with positions 0 to 23. Polarity starts at 0 after reset and flips each time the position returns to 0.
- R4: In master mode, `casc_clk` is bit 3 of a tick counter when `fast_sel`=0, so its period is 16 ticks. When `fast_sel`=1 it is bit 2, for a period of 8 ticks. In slave mode it is held low.
- R5: In master mode, `sync_out` is high exactly while the frame position is 0, and `sync_in` is ignored. In slave mode, `sync_out` is low, and a tick taken with `sync_in` high restarts the frame at position 0.
- R6: In slave mode, every common output is 0 (GND).
- R7: With `disp_on` low, every common and segment output is 0 (GND).
- R8: `blink_rate` 2'b00 keeps `blink_gate` high. For codes 01, 10 and 11, `blink_gate` is the inverse of bit 4, 5 or 6 of a frame counter, giving a blink period of 32, 64 or 128 frames. The counter starts at 0 and counts frame restarts. While the gate is low, every segment is treated as off.
- R9: The active row is the frame position divided by 24/N, where N is the number of active rows. Segment s shows bit `seg_data[row*40+s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period (master clock edge in slave mode) |
| master | input | 1 | 1 = master, 0 = slave |
| sync_in | input | 1 | Frame restart from master (used in slave mode) |
| duty_sel | input | 2 | Duty selection, see R1 |
| half_bias | input | 1 | 1 = one-half bias, 0 = one-third bias |
| fast_sel | input | 1 | Cascade clock divider select |
| disp_on | input | 1 | Display enable |
| blink_rate | input | 2 | Blink period select |
| seg_data | input | 160 | Display rows, row r at bits r*40 upward |
| casc_clk | output | 1 | Divided clock for slaves |
| sync_out | output | 1 | Frame start pulse (master) |
| blink_gate | output | 1 | High while segments may show |
| com_lvl | output | 12 | Common level codes, common k at bits 3k+2:3k |
| seg_lvl | output | 120 | Segment level codes, segment s at bits 3s+2:3s |

## Verification
The only state is the frame position, the polarity, the tick counter and the frame counter, and each of them changes at the clock edge where a tick is taken. The outputs are combinational from that state and the static inputs, so every result is due one clock after the tick. Because of this, the bench pulses the tick on a falling edge, lets the next rising edge take it, and compares all outputs on the falling edge after that, against a model stepped once per tick. Configuration inputs change only between ticks, and a fresh reset follows each change.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int unsigned N_COM = 4;
    localparam int unsigned LVL_W = 3;

    typedef enum logic [2:0] {
        LVL_GND  = 3'd0,
        LVL_ONE3 = 3'd1,
        LVL_HALF = 3'd2,
        LVL_TWO3 = 3'd3,
        LVL_RAIL = 3'd4
    } lvl_e;

    typedef enum logic [1:0] {
        DUTY_STATIC  = 2'b00,
        DUTY_HALF    = 2'b01,
        DUTY_THIRD   = 2'b10,
        DUTY_QUARTER = 2'b11
    } duty_e;

    typedef struct packed {
        logic       pol;
        logic [1:0] row;
        logic       half_bias;
        logic       enable;
    } drive_ctl_t;

    function automatic int unsigned rows_of(input duty_e d);
        case (d)
            DUTY_STATIC: return 1;
            DUTY_HALF:   return 2;
            DUTY_THIRD:  return 3;
            default:     return 4;
        endcase
    endfunction

    // Active row from frame position: position / (frame length / rows)
    function automatic logic [1:0] row_of(input int unsigned pos, input duty_e d,
                                          input int unsigned frame_ticks);
        int unsigned slot;
        int unsigned r;
        slot = frame_ticks / rows_of(d);
        r    = pos / slot;
        if (r > 3) r = 3;
        return r[1:0];
    endfunction

    // Logical row driven by physical common k
    function automatic logic [1:0] com_row(input int unsigned k, input duty_e d);
        case (d)
            DUTY_STATIC: return 2'd0;
            DUTY_HALF:   return 2'(k % 2);
            DUTY_THIRD:  return (k == 3) ? 2'd1 : 2'(k);
            default:     return 2'(k);
        endcase
    endfunction

    function automatic lvl_e com_level(input logic sel, input logic pol, input logic half_b);
        if (sel)    return pol ? LVL_GND : LVL_RAIL;
        if (half_b) return LVL_HALF;
        return pol ? LVL_TWO3 : LVL_ONE3;
    endfunction

    function automatic lvl_e seg_level(input logic on, input logic pol, input logic half_b);
        if (on)     return pol ? LVL_RAIL : LVL_GND;
        if (half_b) return pol ? LVL_GND : LVL_RAIL;
        return pol ? LVL_ONE3 : LVL_TWO3;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_seq_pkg::*;
#(
    parameter int unsigned FRAME_TICKS = 24,
    parameter int unsigned CASC_W      = 4,
    parameter int unsigned BLINK_W     = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           osc_tick,
    input  logic                           master,
    input  logic                           sync_in,
    input  logic                           fast_sel,
    input  logic [1:0]                     blink_rate,
    output logic [$clog2(FRAME_TICKS)-1:0] phase_o,
    output logic                           pol_o,
    output logic                           casc_clk_o,
    output logic                           sync_out_o,
    output logic                           blink_gate_o
);
    localparam int unsigned PH_W = $clog2(FRAME_TICKS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_TICKS - 1);

    logic [PH_W-1:0]    phase_q;
    logic               pol_q;
    logic [CASC_W-1:0]  casc_q;
    logic [BLINK_W-1:0] blink_q;
    logic               restart;
    logic               frame_end;

    assign restart   = !master && sync_in;
    assign frame_end = (phase_q == PH_LAST) || restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            pol_q   <= 1'b0;
            casc_q  <= '0;
            blink_q <= '0;
        end else if (osc_tick) begin
            casc_q <= casc_q + 1'b1;
            if (frame_end) begin
                phase_q <= '0;
                pol_q   <= ~pol_q;
                blink_q <= blink_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    always_comb begin
        case (blink_rate)
            2'b01:   blink_gate_o = ~blink_q[BLINK_W-3];
            2'b10:   blink_gate_o = ~blink_q[BLINK_W-2];
            2'b11:   blink_gate_o = ~blink_q[BLINK_W-1];
            default: blink_gate_o = 1'b1;
        endcase
    end

    assign casc_clk_o = master && (fast_sel ? casc_q[CASC_W-2] : casc_q[CASC_W-1]);
    assign sync_out_o = master && (phase_q == '0);
    assign phase_o    = phase_q;
    assign pol_o      = pol_q;

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q <= PH_LAST); // R3

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (osc_tick && phase_q == PH_LAST) |=> (phase_q == '0 && pol_q != $past(pol_q))); // R3

    AST_SYNC_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        (master && sync_out_o && osc_tick) |=> !sync_out_o); // R5

    AST_CASC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(osc_tick) && $stable(fast_sel) && $stable(master)) |-> $stable(casc_clk_o)); // R4

    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(osc_tick) && $stable(blink_rate)) |-> $stable(blink_gate_o)); // R8

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
    import lcd_seq_pkg::*;
(
    input  drive_ctl_t               ctl_i,
    input  duty_e                    duty_i,
    input  logic                     master_i,
    output logic [N_COM*LVL_W-1:0]   com_lvl_o
);
    for (genvar k = 0; k < N_COM; k++) begin : g_com
        logic sel;
        assign sel = (com_row(k, duty_i) == ctl_i.row);
        assign com_lvl_o[k*LVL_W +: LVL_W] = (ctl_i.enable && master_i)
                                             ? com_level(sel, ctl_i.pol, ctl_i.half_bias)
                                             : LVL_GND;
    end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcd_seq_pkg::*;
#(
    parameter int unsigned N_SEG = 40
) (
    input  drive_ctl_t               ctl_i,
    input  logic [N_COM*N_SEG-1:0]   seg_data_i,
    input  logic                     blink_gate_i,
    output logic [N_SEG*LVL_W-1:0]   seg_lvl_o
);
    logic [N_SEG-1:0] row_bits;
    assign row_bits = seg_data_i[ctl_i.row*N_SEG +: N_SEG];

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic lit;
        assign lit = row_bits[s] && blink_gate_i;
        assign seg_lvl_o[s*LVL_W +: LVL_W] = ctl_i.enable
                                             ? seg_level(lit, ctl_i.pol, ctl_i.half_bias)
                                             : LVL_GND;
    end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned N_SEG       = 40,
    parameter int unsigned FRAME_TICKS = 24,
    parameter int unsigned CASC_W      = 4,
    parameter int unsigned BLINK_W     = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     osc_tick,
    input  logic                     master,
    input  logic                     sync_in,
    input  logic [1:0]               duty_sel,
    input  logic                     half_bias,
    input  logic                     fast_sel,
    input  logic                     disp_on,
    input  logic [1:0]               blink_rate,
    input  logic [N_COM*N_SEG-1:0]   seg_data,
    output logic                     casc_clk,
    output logic                     sync_out,
    output logic                     blink_gate,
    output logic [N_COM*LVL_W-1:0]   com_lvl,
    output logic [N_SEG*LVL_W-1:0]   seg_lvl
);
    localparam int unsigned PH_W = $clog2(FRAME_TICKS);

    logic [PH_W-1:0] phase;
    logic            pol;
    duty_e           duty;
    drive_ctl_t      ctl;

    assign duty = duty_e'(duty_sel);

    lcd_frame_timer #(
        .FRAME_TICKS (FRAME_TICKS),
        .CASC_W      (CASC_W),
        .BLINK_W     (BLINK_W)
    ) timer_i (
        .clk          (clk),
        .rst          (rst),
        .osc_tick     (osc_tick),
        .master       (master),
        .sync_in      (sync_in),
        .fast_sel     (fast_sel),
        .blink_rate   (blink_rate),
        .phase_o      (phase),
        .pol_o        (pol),
        .casc_clk_o   (casc_clk),
        .sync_out_o   (sync_out),
        .blink_gate_o (blink_gate)
    );

    always_comb begin
        ctl.pol       = pol;
        ctl.row       = row_of(int'(phase), duty, FRAME_TICKS);
        ctl.half_bias = half_bias;
        ctl.enable    = disp_on;
    end

    lcd_com_drive com_i (
        .ctl_i     (ctl),
        .duty_i    (duty),
        .master_i  (master),
        .com_lvl_o (com_lvl)
    );

    lcd_seg_drive #(.N_SEG(N_SEG)) seg_i (
        .ctl_i        (ctl),
        .seg_data_i   (seg_data),
        .blink_gate_i (blink_gate),
        .seg_lvl_o    (seg_lvl)
    );

    logic [N_COM-1:0] com_at_rail;
    for (genvar k = 0; k < N_COM; k++) begin : g_rail
        assign com_at_rail[k] = (com_lvl[k*LVL_W +: LVL_W] == LVL_RAIL) ||
                                (com_lvl[k*LVL_W +: LVL_W] == LVL_GND);
    end

    AST_ONE_ROW_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (master && disp_on && duty == DUTY_QUARTER) |-> ($countones(com_at_rail) == 1)); // R1

    AST_SLAVE_COM_GND: assert property (@(posedge clk) disable iff (rst)
        (!master) |-> (com_lvl == '0)); // R6

endmodule

// File: tb/lcd_mux_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_mux_seq_tb_top;
    localparam int NS = 40;
    localparam int FT = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          osc_tick = 1'b0;
    logic          master = 1'b1;
    logic          sync_in = 1'b0;
    logic [1:0]    duty_sel = 2'b11;
    logic          half_bias = 1'b0;
    logic          fast_sel = 1'b0;
    logic          disp_on = 1'b1;
    logic [1:0]    blink_rate = 2'b00;
    logic [159:0]  seg_data = '0;
    logic          casc_clk, sync_out, blink_gate;
    logic [11:0]   com_lvl;
    logic [119:0]  seg_lvl;

    int checks = 0;
    int errors = 0;

    // model state
    int m_phase, m_pol, m_frames, m_ticks;

    always #2 clk = ~clk;

    lcd_mux_seq dut_i (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .master(master), .sync_in(sync_in),
        .duty_sel(duty_sel), .half_bias(half_bias), .fast_sel(fast_sel), .disp_on(disp_on),
        .blink_rate(blink_rate), .seg_data(seg_data), .casc_clk(casc_clk),
        .sync_out(sync_out), .blink_gate(blink_gate), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic int nrows(input logic [1:0] d);
        case (d) 2'b00: return 1; 2'b01: return 2; 2'b10: return 3; default: return 4; endcase
    endfunction

    function automatic int exp_row();
        return m_phase / (FT / nrows(duty_sel));
    endfunction

    function automatic int phys_row(input int k);
        case (duty_sel)
            2'b00: return 0;
            2'b01: return k % 2;
            2'b10: return (k == 3) ? 1 : k;
            default: return k;
        endcase
    endfunction

    function automatic logic exp_gate();
        case (blink_rate)
            2'b01: return ((m_frames / 16) % 2) == 0;
            2'b10: return ((m_frames / 32) % 2) == 0;
            2'b11: return ((m_frames / 64) % 2) == 0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [11:0] exp_com();
        logic [11:0] v = '0;
        for (int k = 0; k < 4; k++) begin
            logic [2:0] l;
            if (!disp_on || !master) l = 3'd0;
            else if (phys_row(k) == exp_row()) l = m_pol ? 3'd0 : 3'd4;
            else if (half_bias) l = 3'd2;
            else l = m_pol ? 3'd3 : 3'd1;
            v[k*3 +: 3] = l;
        end
        return v;
    endfunction

    function automatic logic [119:0] exp_seg();
        logic [119:0] v = '0;
        for (int s = 0; s < NS; s++) begin
            logic [2:0] l;
            logic on;
            on = seg_data[exp_row()*NS + s] && exp_gate();
            if (!disp_on) l = 3'd0;
            else if (on) l = m_pol ? 3'd4 : 3'd0;
            else if (half_bias) l = m_pol ? 3'd0 : 3'd4;
            else l = m_pol ? 3'd1 : 3'd3;
            v[s*3 +: 3] = l;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (phase=%0d pol=%0d)", tag, act, exp, m_phase, m_pol);
        end
    endtask

    task automatic check_all(input string ctag, input string stag);
        logic exp_casc;
        exp_casc = master && (fast_sel ? m_ticks[2] : m_ticks[3]);
        chk(ctag, 128'(com_lvl), 128'(exp_com()));
        chk(stag, 128'(seg_lvl), 128'(exp_seg()));
        chk("R4 casc_clk", 128'(casc_clk), 128'(exp_casc));
        chk("R5 sync_out", 128'(sync_out), 128'(master && m_phase == 0));
        chk("R8 blink_gate", 128'(blink_gate), 128'(exp_gate()));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        osc_tick = 1'b0;
        sync_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_phase = 0; m_pol = 0; m_frames = 0; m_ticks = 0;
    endtask

    task automatic tick(input logic sy, input string ctag, input string stag);
        int gap;
        gap = int'($urandom_range(0, 2));
        for (int i = 0; i < gap; i++) @(negedge clk);
        osc_tick = 1'b1;
        sync_in  = sy;
        @(negedge clk);
        osc_tick = 1'b0;
        sync_in  = 1'b0;
        m_ticks++;
        if ((!master && sy) || m_phase == FT - 1) begin
            m_phase = 0; m_pol ^= 1; m_frames++;
        end else begin
            m_phase++;
        end
        check_all(ctag, stag);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_phase = 0; m_pol = 0; m_frames = 0; m_ticks = 0;
        do_reset();
        // reset state
        check_all("R3 reset com", "R3 reset seg");

        // R1 R2 R9: every duty and bias, master, random data
        for (int c = 0; c < 8; c++) begin
            duty_sel   = 2'(c % 4);
            half_bias  = c[2];
            fast_sel   = $urandom_range(0, 1) == 1;
            disp_on    = 1'b1;
            blink_rate = 2'b00;
            seg_data   = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
            do_reset();
            for (int t = 0; t < 80; t++) tick(1'b0, "R1 R9 com", "R2 R9 seg");
        end

        // directed: all-on and all-off data, quarter duty, both biases
        duty_sel = 2'b11;
        for (int b = 0; b < 2; b++) begin
            half_bias = b[0];
            seg_data = (b == 0) ? '1 : '0;
            do_reset();
            for (int t = 0; t < 50; t++) tick(1'b0, "R2 com", "R2 seg");
        end

        // R5: master ignores sync_in
        seg_data = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        do_reset();
        for (int t = 0; t < 30; t++) tick(($urandom_range(0, 3) == 0), "R5 com", "R5 seg");

        // R7: display off
        disp_on = 1'b0;
        do_reset();
        for (int t = 0; t < 30; t++) tick(1'b0, "R7 com", "R7 seg");
        disp_on = 1'b1;

        // R6, R5: slave, commons at ground, restarts on sync
        master = 1'b0;
        duty_sel = 2'b10;
        do_reset();
        for (int t = 0; t < 150; t++) tick(($urandom_range(0, 9) == 0), "R6 com", "R5 seg");
        master = 1'b1;

        // R8: blink periods
        duty_sel = 2'b01;
        seg_data = '1;
        for (int r = 1; r < 4; r++) begin
            blink_rate = 2'(r);
            do_reset();
            for (int t = 0; t < ((r == 3) ? 64 * FT + 30 : 34 * FT); t++)
                tick(1'b0, "R8 com", "R8 seg");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule